// File: doc/BRIEF.md
# PCI Burst Read Command Selector

This block decides which PCI read command a DMA engine places on the bus for each read burst it starts. Every burst begins as a plain Memory Read. The block upgrades it to Memory Read Line or Memory Read Multiple only when a set of conditions all hold together:

- the configuration enables allow the upgrade;
- the programmed cache line size is usable and fits in the burst;
- the start address sits on a line boundary;
- enough bytes remain in the transfer.

Opcode fetches are never sent as Memory Read Multiple.

The DMA engine presents the enable bits, the cache line size (in bytes), the burst size (in bytes), the current address, the remaining byte count and an opcode-fetch flag, then pulses a start strobe. One clock later the chosen 4-bit command appears in a register, together with a single-cycle valid pulse for the bus master. The command stays in that register until the next strobe. The bus protocol engine, the data path and register access lie outside this block.

Top module: `pci_rd_cmd_sel`

## Requirements
- R1: A synchronous active-high reset sets the command output to 4'b0000 and the valid output to 0.
- R2: A start strobe sampled at a clock edge makes the valid output high for exactly the following cycle. The command output updates only on such an edge, and changes to any input while start is low have no effect on it.
- R3: A cache line size counts as usable only if it is one of 2, 4, 8, 16, 32, 64 or 128 bytes and is no larger than the burst size. Otherwise the command is Memory Read (4'b0110).
- R4: An upgraded command is chosen only when the address is a whole multiple of the cache line size. Otherwise the command is Memory Read (4'b0110).
- R5: Memory Read Line (4'b1110) is chosen only when the cache-line enable and the line-read enable are both set, the line size is usable, the address is aligned, and the remaining byte count is at least the burst size.
- R6: Memory Read Multiple (4'b1100) is chosen only when the cache-line enable and the multiple-read enable are both set, the line size is usable, the address is aligned, and the remaining byte count is at least twice the line size.
- R7: An opcode fetch never yields Memory Read Multiple. It takes Memory Read Line if the R5 conditions hold, and Memory Read (4'b0110) otherwise.
- R8: When the conditions for both upgrades hold, Memory Read Multiple (4'b1100) wins.
- R9: When no upgrade qualifies, Memory Read (4'b0110) is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_en | input | 1 | Cache-line size enable |
| line_rd_en | input | 1 | Allows Memory Read Line |
| mult_rd_en | input | 1 | Allows Memory Read Multiple |
| line_sz | input | LINE_W (8) | Cache line size in bytes |
| burst_sz | input | BURST_W (16) | DMA burst size in bytes |
| addr | input | ADDR_W (32) | Current burst start address |
| remain | input | CNT_W (24) | Bytes still to transfer |
| op_fetch | input | 1 | Burst is an opcode fetch |
| start | input | 1 | Burst start strobe |
| cmd | output | 4 | Registered PCI bus command |
| cmd_vld | output | 1 | One-cycle valid pulse for cmd |

## Verification
The bench sweeps every combination of the three enables and the fetch flag against a range of line sizes: legal sizes, zero, one, a non-power-of-two value and a size larger than the burst. It also varies addresses aligned to some line sizes but not others, and remaining counts that sit exactly on the burst-size and twice-line-size thresholds. A design that used a strict comparison at either threshold, or that let a zero or one-byte line size pass, would upgrade or withhold upgrades in the wrong rows. A design that let an opcode fetch through to Multiple, or that gave Line priority, would miscompare on the fetch and overlap rows. Checks made while start is low with scrambled inputs catch a command register that follows its inputs instead of the strobe.

// File: rtl/pci_rdsel_pkg.sv
package pci_rdsel_pkg;

    typedef enum logic [3:0] {
        CMD_NONE      = 4'b0000,
        CMD_MEM_READ  = 4'b0110,
        CMD_READ_MULT = 4'b1100,
        CMD_READ_LINE = 4'b1110
    } bus_cmd_e;

    // Per-burst grant flags produced by the qualifier.
    typedef struct packed {
        logic line_grant;
        logic mult_grant;
    } qual_t;

    localparam int unsigned LINE_MIN_BYTES = 2;
    localparam int unsigned LINE_MAX_BYTES = 128;

    // Usable line size: power of two within [LINE_MIN_BYTES, LINE_MAX_BYTES].
    function automatic logic line_size_legal(input logic [31:0] v);
        return (v >= LINE_MIN_BYTES) && (v <= LINE_MAX_BYTES) &&
               ((v & (v - 32'd1)) == 32'd0);
    endfunction

endpackage

// File: rtl/rdsel_qualify.sv
module rdsel_qualify
    import pci_rdsel_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 24,
    parameter int LINE_W  = 8,
    parameter int BURST_W = 16
) (
    input  logic               cls_en,
    input  logic               line_rd_en,
    input  logic               mult_rd_en,
    input  logic [LINE_W-1:0]  line_sz,
    input  logic [BURST_W-1:0] burst_sz,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   remain,
    input  logic               op_fetch,
    output qual_t              q
);

    logic [ADDR_W-1:0] line_mask;
    logic              size_ok;
    logic              fits_burst;
    logic              aligned;
    logic              base_ok;
    logic              len_line;
    logic              len_mult;

    always_comb begin
        line_mask  = ADDR_W'(line_sz) - ADDR_W'(1);
        size_ok    = line_size_legal(32'(line_sz));
        fits_burst = BURST_W'(line_sz) <= burst_sz;
        aligned    = (addr & line_mask) == '0;
        base_ok    = cls_en && size_ok && fits_burst && aligned;
        len_line   = remain >= CNT_W'(burst_sz);
        len_mult   = remain >= CNT_W'({line_sz, 1'b0});

        q.line_grant = base_ok && line_rd_en && len_line;
        q.mult_grant = base_ok && mult_rd_en && !op_fetch && len_mult;
    end

endmodule

// File: rtl/rdsel_pick.sv
module rdsel_pick
    import pci_rdsel_pkg::*;
#(
    parameter bit MULT_FIRST = 1'b1
) (
    input  qual_t    q,
    output bus_cmd_e sel
);

    generate
        if (MULT_FIRST) begin : g_mult_first
            always_comb begin
                if (q.mult_grant)      sel = CMD_READ_MULT;
                else if (q.line_grant) sel = CMD_READ_LINE;
                else                   sel = CMD_MEM_READ;
            end
        end else begin : g_line_first
            always_comb begin
                if (q.line_grant)      sel = CMD_READ_LINE;
                else if (q.mult_grant) sel = CMD_READ_MULT;
                else                   sel = CMD_MEM_READ;
            end
        end
    endgenerate

endmodule

// File: rtl/pci_rd_cmd_sel.sv
module pci_rd_cmd_sel
    import pci_rdsel_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 24,
    parameter int LINE_W     = 8,
    parameter int BURST_W    = 16,
    parameter bit MULT_FIRST = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cls_en,
    input  logic               line_rd_en,
    input  logic               mult_rd_en,
    input  logic [LINE_W-1:0]  line_sz,
    input  logic [BURST_W-1:0] burst_sz,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   remain,
    input  logic               op_fetch,
    input  logic               start,
    output logic [3:0]         cmd,
    output logic               cmd_vld
);

    qual_t    qual;
    bus_cmd_e next_cmd;
    bus_cmd_e cmd_q;
    logic     vld_q;

    rdsel_qualify #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .LINE_W (LINE_W),
        .BURST_W(BURST_W)
    ) qual_i (
        .cls_en    (cls_en),
        .line_rd_en(line_rd_en),
        .mult_rd_en(mult_rd_en),
        .line_sz   (line_sz),
        .burst_sz  (burst_sz),
        .addr      (addr),
        .remain    (remain),
        .op_fetch  (op_fetch),
        .q         (qual)
    );

    rdsel_pick #(
        .MULT_FIRST(MULT_FIRST)
    ) pick_i (
        .q  (qual),
        .sel(next_cmd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_NONE;
            vld_q <= 1'b0;
        end else begin
            vld_q <= start;
            if (start) cmd_q <= next_cmd;
        end
    end

    assign cmd     = cmd_q;
    assign cmd_vld = vld_q;

endmodule

// File: rtl/rdsel_checker.sv
module rdsel_checker #(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 24,
    parameter int LINE_W  = 8,
    parameter int BURST_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               cls_en,
    input logic               line_rd_en,
    input logic               mult_rd_en,
    input logic [LINE_W-1:0]  line_sz,
    input logic [BURST_W-1:0] burst_sz,
    input logic [ADDR_W-1:0]  addr,
    input logic [CNT_W-1:0]   remain,
    input logic               op_fetch,
    input logic               start,
    input logic [3:0]         cmd,
    input logic               cmd_vld
);

    p_vld_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> cmd_vld);

    p_vld_single_r2: assert property (@(posedge clk) disable iff (rst)
        !start |=> !cmd_vld);

    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(cmd));

    p_known_code_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_vld |-> (cmd == 4'b0110 || cmd == 4'b1100 || cmd == 4'b1110));

    p_line_enables_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd == 4'b1110) |-> $past(cls_en && line_rd_en));

    p_line_length_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd == 4'b1110) |-> $past(remain >= CNT_W'(burst_sz)));

    p_mult_enables_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd == 4'b1100) |-> $past(cls_en && mult_rd_en));

    p_mult_length_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd == 4'b1100) |-> $past(remain >= CNT_W'({line_sz, 1'b0})));

    p_no_mult_fetch_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd == 4'b1100) |-> $past(!op_fetch));

    p_upgrade_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd != 4'b0110) |->
            $past((addr & (ADDR_W'(line_sz) - ADDR_W'(1))) == '0));

endmodule

bind pci_rd_cmd_sel rdsel_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .LINE_W (LINE_W),
    .BURST_W(BURST_W)
) chk_i (.*);

// File: tb/pci_rd_cmd_sel_tb_top.sv
module pci_rd_cmd_sel_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cls_en = 1'b0, line_rd_en = 1'b0, mult_rd_en = 1'b0;
    logic [7:0]  line_sz = '0;
    logic [15:0] burst_sz = '0;
    logic [31:0] addr = '0;
    logic [23:0] remain = '0;
    logic        op_fetch = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cmd;
    logic        cmd_vld;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    pci_rd_cmd_sel dut_i (
        .clk(clk), .rst(rst), .cls_en(cls_en), .line_rd_en(line_rd_en),
        .mult_rd_en(mult_rd_en), .line_sz(line_sz), .burst_sz(burst_sz),
        .addr(addr), .remain(remain), .op_fetch(op_fetch), .start(start),
        .cmd(cmd), .cmd_vld(cmd_vld)
    );

    int line_tab[8]   = '{0, 1, 2, 6, 8, 16, 64, 128};
    int burst_tab[3]  = '{8, 64, 128};
    int addr_tab[3]   = '{32'h1000, 32'h1040, 32'h1004};
    int remain_tab[5] = '{0, 16, 64, 128, 256};

    function automatic bit legal_line(int ln);
        return ln == 2 || ln == 4 || ln == 8 || ln == 16 ||
               ln == 32 || ln == 64 || ln == 128;
    endfunction

    function automatic logic [3:0] model(bit c, bit l, bit m, bit f,
                                         int ln, int bu, int ad, int rm);
        bit base, rl, mu;
        base = c && legal_line(ln) && ln <= bu && ((ln == 0) ? 1'b0 : (ad % ln) == 0);
        rl   = base && l && rm >= bu;
        mu   = base && m && !f && rm >= 2 * ln;
        return mu ? 4'b1100 : (rl ? 4'b1110 : 4'b0110);
    endfunction

    function automatic string pick_tag(bit c, bit l, bit m, bit f,
                                       int ln, int bu, int ad, int rm, logic [3:0] e);
        bit base;
        base = c && legal_line(ln) && ln <= bu && ((ln == 0) ? 1'b0 : (ad % ln) == 0);
        if (f && m && base) return "R7";
        if (e == 4'b1100 && l && rm >= bu) return "R8";
        if (e == 4'b1100) return "R6";
        if (e == 4'b1110) return "R5";
        if (c && !(legal_line(ln) && ln <= bu)) return "R3";
        if (c && legal_line(ln) && ln <= bu) return "R4";
        return "R9";
    endfunction

    task automatic check(string tag, logic [3:0] act_cmd, logic [3:0] exp_cmd,
                         logic act_v, logic exp_v);
        vectors++;
        if (act_cmd !== exp_cmd || act_v !== exp_v) begin
            miscompares++;
            $display("FAIL %s: cmd=%b vld=%b expected cmd=%b vld=%b",
                     tag, act_cmd, act_v, exp_cmd, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", cmd, 4'b0000, cmd_vld, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", cmd, 4'b0000, cmd_vld, 1'b0);

        for (int en = 0; en < 16; en++) begin
            for (int li = 0; li < 8; li++) begin
                for (int bi = 0; bi < 3; bi++) begin
                    for (int ai = 0; ai < 3; ai++) begin
                        for (int ri = 0; ri < 5; ri++) begin
                            logic [3:0] exp;
                            string tag;
                            exp = model(en[0], en[1], en[2], en[3], line_tab[li],
                                        burst_tab[bi], addr_tab[ai], remain_tab[ri]);
                            tag = pick_tag(en[0], en[1], en[2], en[3], line_tab[li],
                                           burst_tab[bi], addr_tab[ai], remain_tab[ri], exp);
                            cls_en     = en[0];
                            line_rd_en = en[1];
                            mult_rd_en = en[2];
                            op_fetch   = en[3];
                            line_sz    = 8'(line_tab[li]);
                            burst_sz   = 16'(burst_tab[bi]);
                            addr       = addr_tab[ai];
                            remain     = 24'(remain_tab[ri]);
                            start      = 1'b1;
                            @(negedge clk);
                            start = 1'b0;
                            check(tag, cmd, exp, cmd_vld, 1'b1);
                            // R2: scramble inputs with start low; command must hold.
                            cls_en     = ~cls_en;
                            mult_rd_en = ~mult_rd_en;
                            line_rd_en = ~line_rd_en;
                            addr       = 32'h1001;
                            @(negedge clk);
                            check("R2", cmd, exp, cmd_vld, 1'b0);
                        end
                    end
                end
            end
        end

        // R1: reset wins over a simultaneous start.
        cls_en = 1'b1; line_rd_en = 1'b1; mult_rd_en = 1'b1; op_fetch = 1'b0;
        line_sz = 8'd8; burst_sz = 16'd8; addr = 32'h100; remain = 24'd64;
        start = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R1", cmd, 4'b0000, cmd_vld, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check("R8", cmd, 4'b1100, cmd_vld, 1'b1);
        @(negedge clk);
        finish_run();
    end

endmodule